// File: doc/BRIEF.md
# Host Command Interrupt Handshake

This block holds a command register that an external host writes to ask an embedded core for a vectored interrupt. A single host write carries a request bit and a 7-bit vector. When the request bit is written as 1, a pending flag and the vector go to the core. The core later answers with an acknowledge, which clears the request. The host can read the request bit back at any time and use it to poll for completion.

The register is guarded while a request is outstanding. A host write that arrives then is not accepted. It is stalled on the bus in one of two ways, picked by a mode input:
- **Generic mode:** the acknowledge to the host is withheld for as long as the request stands.
- **PCI-style mode:** the target-ready is withheld for at most eight wait cycles. If the request is still set after that, the block ends the transfer with a retry and drops the written data.

Top module: `hci_cmd_handshake`

## Requirements
- R1: After reset, the request bit, the pending flag and the vector are all 0, and `host_ready` and `host_retry` are both low.
- R2: A host write with `host_cmd`=1 while the request bit is 0 raises `host_ready` combinationally in that same cycle. From the next cycle on, the request bit and the pending flag are 1 and `core_vec` holds the written vector.
- R3: A host write with `host_cmd`=0 while the request bit is 0 is accepted. It loads the vector, and the request bit and the pending flag stay 0, because writing 0 has no effect on the bit.
- R4: When `core_ack` is high while the request bit is 1, the request bit and the pending flag both read 0 from the next cycle on. The vector is kept.
- R5: A `core_ack` while the request bit is 0 changes no output.
- R6: While the request bit is 1, `host_ready` stays low for a pending write. A write that is still held when the bit clears is accepted in the first cycle after the clear.
- R7: With `bus_mode`=0 (PCI-style), a write held against a set request bit sees eight cycles with both `host_ready` and `host_retry` low. In the ninth cycle `host_retry` is high for one cycle and the write is discarded: the request bit and the vector are unchanged. A write still held after that starts a fresh eight-cycle window.
- R8: With `bus_mode`=1 (generic), a held write waits with `host_ready` low for any number of cycles, and `host_retry` never rises.
- R9: The pending flag seen by the core always equals the request bit the host reads.
- R10: `host_ready` and `host_retry` are never high together, and neither is high without `host_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_mode | input | 1 | 0 = PCI-style bounded wait with retry, 1 = generic unbounded wait |
| host_wr | input | 1 | Host write to the command register, held until ready or retry |
| host_cmd | input | 1 | Request bit value being written |
| host_vec | input | VEC_W (7) | Interrupt vector being written |
| host_ready | output | 1 | Write accepted this cycle (target-ready / transfer-acknowledge) |
| host_retry | output | 1 | PCI-style termination without data; the write is discarded |
| host_cmd_rd | output | 1 | Request bit as read by the host |
| core_pending | output | 1 | Command-pending flag in the core status |
| core_vec | output | VEC_W (7) | Stored interrupt vector |
| core_ack | input | 1 | Core acknowledges the interrupt |

## Verification
`host_ready` and `host_retry` are combinational from `host_wr`, the stored request bit and the wait count, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples these two outputs 2 ns later. The request bit, the pending flag and the vector pass through one register each, so they change on the first rising edge after the write or acknowledge, and the bench samples them 2 ns after that edge. For the retry window the bench counts the falling edges during which it holds the write. It expects eight quiet cycles and a retry in the ninth.

// File: rtl/hci_pkg.sv
package hci_pkg;
  typedef enum logic {
    MODE_PCI = 1'b0,
    MODE_GEN = 1'b1
  } bus_mode_e;

  // True once the stall has lasted the whole permitted window.
  function automatic logic wait_spent(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

  // A host write lands only while no request is outstanding.
  function automatic logic write_lands(input logic wr, input logic busy);
    return wr && !busy;
  endfunction
endpackage

// File: rtl/hci_wait_timer.sv
module hci_wait_timer #(
  parameter int unsigned MAX_WAIT = 8,
  localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall,     // write held against a set request bit
  input  logic gen_mode,  // 1 = unbounded wait
  output logic retry
);
  import hci_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             counting;

  assign counting = stall && !gen_mode;
  assign retry    = counting && wait_spent(32'(cnt_q), MAX_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n || !counting || retry) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= MAX_WAIT);
  p_retry_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retry |=> !retry);
  p_no_retry_gen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gen_mode |-> !retry);
endmodule

// File: rtl/hci_cmd_reg.sv
module hci_cmd_reg #(
  parameter int unsigned VEC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,    // host write lands this cycle
  input  logic             wr_cmd,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic             ack,
  output logic             cmd_q,
  output logic [VEC_W-1:0] vec_q,
  output logic             set_ev,
  output logic             clr_ev
);
  // Internal events brought out for the status flop and the assertions.
  assign set_ev = accept && wr_cmd;
  assign clr_ev = ack && cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (accept) vec_q <= wr_vec;
      if (set_ev)      cmd_q <= 1'b1;
      else if (clr_ev) cmd_q <= 1'b0;
    end
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> cmd_q);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> !cmd_q);
  p_zero_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wr_cmd && !cmd_q) |=> !cmd_q);
  p_hold_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q && !accept) |=> $stable(vec_q));
endmodule

// File: rtl/hci_core_status.sv
module hci_core_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pending <= 1'b0;
    else if (set_ev) pending <= 1'b1;
    else if (clr_ev) pending <= 1'b0;
  end
endmodule

// File: rtl/hci_cmd_handshake.sv
module hci_cmd_handshake #(
  parameter int unsigned VEC_W    = 7,
  parameter int unsigned MAX_WAIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_mode,
  input  logic             host_wr,
  input  logic             host_cmd,
  input  logic [VEC_W-1:0] host_vec,
  output logic             host_ready,
  output logic             host_retry,
  output logic             host_cmd_rd,
  output logic             core_pending,
  output logic [VEC_W-1:0] core_vec,
  input  logic             core_ack
);
  import hci_pkg::*;

  logic cmd_q, set_ev, clr_ev, stall, gen_mode;

  assign gen_mode   = (bus_mode == MODE_GEN);
  assign host_ready = write_lands(host_wr, cmd_q);
  assign stall      = host_wr && cmd_q;

  hci_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .stall(stall), .gen_mode(gen_mode),
    .retry(host_retry)
  );

  hci_cmd_reg #(.VEC_W(VEC_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .accept(host_ready), .wr_cmd(host_cmd),
    .wr_vec(host_vec), .ack(core_ack), .cmd_q(cmd_q), .vec_q(core_vec),
    .set_ev(set_ev), .clr_ev(clr_ev)
  );

  hci_core_status u_status (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev),
    .pending(core_pending)
  );

  assign host_cmd_rd = cmd_q;

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_ready && host_retry));
  p_need_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready || host_retry) |-> host_wr);
  p_pend_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_pending == host_cmd_rd);
  p_busy_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_cmd_rd |-> !host_ready);
  p_idle_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_cmd_rd) |-> host_ready);
  p_ignored_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ack && !host_cmd_rd && !host_wr) |=> (!host_cmd_rd && $stable(core_vec)));
endmodule

// File: tb/hci_cmd_handshake_tb.sv
module hci_cmd_handshake_tb;
  localparam int VEC_W = 7;
  logic clk = 1'b0;
  logic rst_n, bus_mode, host_wr, host_cmd, core_ack;
  logic [VEC_W-1:0] host_vec;
  logic host_ready, host_retry, host_cmd_rd, core_pending;
  logic [VEC_W-1:0] core_vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  hci_cmd_handshake u_dut (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .host_wr(host_wr),
    .host_cmd(host_cmd), .host_vec(host_vec), .host_ready(host_ready),
    .host_retry(host_retry), .host_cmd_rd(host_cmd_rd),
    .core_pending(core_pending), .core_vec(core_vec), .core_ack(core_ack)
  );

  // {mode, wr, cmd, vec, ack, exp_ready, exp_retry, exp_cmd_next, exp_vec_next}
  localparam int NV = 11;
  localparam logic [20:0] TBL [NV] = '{
    {1'b0,1'b1,1'b1,7'h15,1'b0, 1'b1,1'b0, 1'b1,7'h15}, // R2 set
    {1'b0,1'b1,1'b1,7'h2A,1'b0, 1'b0,1'b0, 1'b1,7'h15}, // R6 stalled
    {1'b0,1'b1,1'b1,7'h2A,1'b1, 1'b0,1'b0, 1'b0,7'h15}, // R4 ack clears
    {1'b0,1'b1,1'b1,7'h2A,1'b0, 1'b1,1'b0, 1'b1,7'h2A}, // R6 held write lands
    {1'b0,1'b0,1'b0,7'h00,1'b1, 1'b0,1'b0, 1'b0,7'h2A}, // R4
    {1'b0,1'b0,1'b0,7'h00,1'b1, 1'b0,1'b0, 1'b0,7'h2A}, // R5 idle ack
    {1'b0,1'b1,1'b0,7'h7F,1'b0, 1'b1,1'b0, 1'b0,7'h7F}, // R3 write of 0
    {1'b1,1'b1,1'b1,7'h01,1'b0, 1'b1,1'b0, 1'b1,7'h01}, // R2 generic
    {1'b1,1'b1,1'b0,7'h55,1'b0, 1'b0,1'b0, 1'b1,7'h01}, // R8 stall
    {1'b1,1'b1,1'b0,7'h55,1'b1, 1'b0,1'b0, 1'b0,7'h01}, // R4 generic
    {1'b1,1'b1,1'b0,7'h55,1'b0, 1'b1,1'b0, 1'b0,7'h55}  // R3 lands after clear
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic w, input logic c, input logic [6:0] v, input logic a);
    @(negedge clk);
    bus_mode = m; host_wr = w; host_cmd = c; host_vec = v; core_ack = a;
    #2;
  endtask

  task automatic state_chk(input string req, input logic c, input logic [6:0] v);
    @(posedge clk); #2;
    chk(req, {7'd0, host_cmd_rd}, {7'd0, c});
    chk("R9", {7'd0, core_pending}, {7'd0, c});
    chk(req, {1'b0, core_vec}, {1'b0, v});
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 0; bus_mode = 0; host_wr = 0; host_cmd = 0; host_vec = '0; core_ack = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    do_reset();
    #2;
    chk("R1", {7'd0, host_cmd_rd}, 8'd0);
    chk("R1", {7'd0, core_pending}, 8'd0);
    chk("R1", {1'b0, core_vec}, 8'd0);
    chk("R1", {6'd0, host_ready, host_retry}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] e;
      e = TBL[i];
      drive(e[20], e[19], e[18], e[17:11], e[10]);
      chk("R6/R10 ready", {7'd0, host_ready}, {7'd0, e[9]});
      chk("R10 retry", {7'd0, host_retry}, {7'd0, e[8]});
      state_chk("R2/R3/R4/R5 state", e[7], e[6:0]);
    end

    // R7: bounded wait then retry in PCI-style mode
    do_reset();
    drive(1'b0, 1'b1, 1'b1, 7'h11, 1'b0);
    chk("R2", {7'd0, host_ready}, 8'd1);
    for (int i = 0; i < 8; i++) begin
      drive(1'b0, 1'b1, 1'b1, 7'h22, 1'b0);
      chk("R7 wait", {6'd0, host_ready, host_retry}, 8'd0);
    end
    drive(1'b0, 1'b1, 1'b1, 7'h22, 1'b0);
    chk("R7 retry", {6'd0, host_ready, host_retry}, 8'd1);
    state_chk("R7 discard", 1'b1, 7'h11);
    drive(1'b0, 1'b1, 1'b1, 7'h22, 1'b0);
    chk("R7 restart", {6'd0, host_ready, host_retry}, 8'd0);
    drive(1'b0, 1'b0, 1'b0, 7'h00, 1'b1);
    state_chk("R4", 1'b0, 7'h11);

    // R8: unbounded wait in generic mode
    drive(1'b1, 1'b1, 1'b1, 7'h33, 1'b0);
    chk("R2", {7'd0, host_ready}, 8'd1);
    for (int i = 0; i < 20; i++) begin
      drive(1'b1, 1'b1, 1'b1, 7'h44, 1'b0);
      chk("R8 wait", {6'd0, host_ready, host_retry}, 8'd0);
    end
    drive(1'b1, 1'b1, 1'b1, 7'h44, 1'b1);
    chk("R8 ack cycle", {6'd0, host_ready, host_retry}, 8'd0);
    drive(1'b1, 1'b1, 1'b1, 7'h44, 1'b0);
    chk("R6 lands", {6'd0, host_ready, host_retry}, 8'd2);
    state_chk("R6 state", 1'b1, 7'h44);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule